// File: doc/BRIEF.md
# Programmable FIFO Status Flag Generator

This block derives the half-full, almost-empty and almost-full indications of a FIFO from occupancy counts that the surrounding logic has already brought into the right clock domain. It sits beside the empty/full (or ready) logic of the FIFO core and adds the partial-level warnings. Each of the two partial flags has its own threshold register.

The thresholds are set in one of three ways. A master reset loads both thresholds with one of two built-in defaults, and a strap input picks which default applies. Software-free configuration after reset uses either a serial path, with one bit per write clock, or a parallel path, with one data byte per write. A small step counter walks the bytes in a fixed order. A partial reset clears the flags and rewinds both loading sequences, but it keeps the thresholds that were programmed.

The almost-empty flag is produced in the read clock domain. The almost-full and half-full flags are produced in the write clock domain. All three flags come from registers, so they cannot glitch.

Top module: `pfifo_status_flags`

## Requirements
- R1: While `mrst` is high, each flag register loads its idle value one clock later: `almost_empty`=1, `almost_full`=0, `half_full`=0. Both thresholds load 7 when `def_sel`=0 or 1023 when `def_sel`=1. `def_sel` has no effect outside master reset.
- R2: `almost_empty` is registered on `rd_clk`. It is 1 exactly when `rd_count` at the previous edge is less than or equal to the almost-empty threshold.
- R3: `almost_full` is registered on `wr_clk`. It is 1 exactly when the free space (2^AW − `wr_count`) at the previous edge is less than or equal to the almost-full threshold.
- R4: `half_full` is registered on `wr_clk`. It is 1 exactly when `wr_count` at the previous edge is greater than 2^(AW−1).
- R5: A write clock edge with `ld`=1 and `wr_en`=1 stores `din` as one threshold byte. The order of bytes is: almost-empty low byte, almost-empty high byte, almost-full low byte, almost-full high byte. The sequence then wraps to the first byte. Bits above the threshold width are dropped.
- R6: A write clock edge with `ser_en`=1 and no parallel write stores `ser_in` as one threshold bit. The order is the almost-empty threshold from bit 0 up to its top bit, then the almost-full threshold from bit 0 up to its top bit. The sequence then wraps.
- R7: When a parallel write and `ser_en` fall in the same edge, only the parallel write takes effect. The serial sequence does not advance.
- R8: `wr_en` without `ld`, and `ld` without `wr_en`, change neither the thresholds nor the byte sequence position.
- R9: `prst` forces the flags to their idle values and rewinds both load sequences to their first position. It leaves both thresholds unchanged, and load inputs are ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| def_sel | input | 1 | Default threshold strap (0: 7, 1: 1023), sampled during master reset |
| wr_en | input | 1 | Write enable, qualifies a parallel threshold load |
| ld | input | 1 | Threshold load strobe |
| din | input | DW | Parallel threshold byte |
| ser_en | input | 1 | Serial threshold load enable |
| ser_in | input | 1 | Serial threshold data bit |
| wr_count | input | AW+1 | Occupancy as seen in the write domain |
| rd_count | input | AW+1 | Occupancy as seen in the read domain |
| almost_empty | output | 1 | Occupancy at or below the almost-empty threshold |
| almost_full | output | 1 | Free space at or below the almost-full threshold |
| half_full | output | 1 | Occupancy above half the depth |

## Verification
Each threshold is located by probing the occupancy count on both sides of the boundary, at the threshold and one word past it. This separates an off-by-one compare, or a strict compare used where a non-strict one belongs, from a correct one. Thresholds are programmed through both strap defaults, a parallel byte sequence, and a serial bit stream. The values chosen have distinct low and high bytes and asymmetric bits, so a swapped byte order, a reversed bit order or a mixed-up offset would move the boundary. Colliding serial and parallel loads, stray strobes, and a partial reset issued part-way through both sequences show whether the sequence positions and stored thresholds are kept or rewound as required.

// File: rtl/pf_pkg.sv
package pf_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/pf_offsets.sv
module pf_offsets #(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 1023
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          def_sel,
  input  logic          wr_en,
  input  logic          ld,
  input  logic [DW-1:0] din,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  localparam int OFFW  = AW;
  localparam int BYTES = pf_pkg::ceil_div(OFFW, DW);
  localparam int NSTEP = 2 * BYTES;
  localparam int PW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  localparam int NBIT  = 2 * OFFW;
  localparam int SW    = $clog2(NBIT);
  localparam logic [OFFW-1:0] LO_V = OFFW'(DEF_LO);
  localparam logic [OFFW-1:0] HI_V = OFFW'(DEF_HI);

  logic          par_wr, ser_wr;
  logic [PW-1:0] step_q;
  logic [SW-1:0] sbit_q;
  logic [NBIT-1:0] ofs_q;

  assign par_wr = ld & wr_en;
  assign ser_wr = ser_en & ~par_wr;

  // Byte sequence position for parallel loading
  always_ff @(posedge clk) begin
    if (mrst || prst)   step_q <= '0;
    else if (par_wr)    step_q <= (step_q == PW'(NSTEP - 1)) ? '0 : step_q + 1'b1;
  end

  // Bit sequence position for serial loading
  always_ff @(posedge clk) begin
    if (mrst || prst)   sbit_q <= '0;
    else if (ser_wr)    sbit_q <= (sbit_q == SW'(NBIT - 1)) ? '0 : sbit_q + 1'b1;
  end

  // One storage bit per threshold bit, each with its own parallel and serial address
  for (genvar g = 0; g < NBIT; g++) begin : g_bit
    localparam int OSEL = g / OFFW;
    localparam int BPOS = g % OFFW;
    localparam int STEP = OSEL * BYTES + BPOS / DW;
    localparam int DPOS = BPOS % DW;
    always_ff @(posedge clk) begin
      if (mrst)
        ofs_q[g] <= def_sel ? HI_V[BPOS] : LO_V[BPOS];
      else if (!prst) begin
        if (par_wr && step_q == PW'(STEP))    ofs_q[g] <= din[DPOS];
        else if (ser_wr && sbit_q == SW'(g))  ofs_q[g] <= ser_in;
      end
    end
  end

  assign ae_off = ofs_q[OFFW-1:0];
  assign af_off = ofs_q[NBIT-1:OFFW];

  assert_prst_keeps_R9: assert property (@(posedge clk) disable iff (mrst)
    prst |=> $stable(ofs_q));
  assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (mrst || prst)
    (!par_wr && !ser_en) |=> ($stable(ofs_q) && $stable(step_q)));
  assert_par_holds_serial_R7: assert property (@(posedge clk) disable iff (mrst || prst)
    par_wr |=> $stable(sbit_q));
endmodule

// File: rtl/pf_rd_flag.sv
module pf_rd_flag #(
  parameter int AW = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] rd_count,
  input  logic [AW-1:0] ae_off,
  output logic        almost_empty
);
  always_ff @(posedge clk) begin
    if (rst) almost_empty <= 1'b1;
    else     almost_empty <= (rd_count <= {1'b0, ae_off});
  end

  assert_empty_is_ae_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_count == '0) |=> almost_empty);
endmodule

// File: rtl/pf_wr_flags.sv
module pf_wr_flags #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW:0]   wr_count,
  input  logic [AW-1:0] af_off,
  output logic          almost_full,
  output logic          half_full
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_V = CW'(1 << AW);
  localparam logic [CW-1:0] HALF_V  = CW'(1 << (AW - 1));

  logic [CW-1:0] free_w;
  assign free_w = DEPTH_V - wr_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      almost_full <= 1'b0;
      half_full   <= 1'b0;
    end else begin
      almost_full <= (free_w <= {1'b0, af_off});
      half_full   <= (wr_count > HALF_V);
    end
  end

  assert_full_is_af_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_count == DEPTH_V) |=> almost_full);
  assert_low_not_hf_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_count <= HALF_V) |=> !half_full);
  assert_full_is_hf_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_count == DEPTH_V) |=> half_full);
endmodule

// File: rtl/pfifo_status_flags.sv
module pfifo_status_flags #(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 1023
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          def_sel,
  input  logic          wr_en,
  input  logic          ld,
  input  logic [DW-1:0] din,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic [AW:0]   wr_count,
  input  logic [AW:0]   rd_count,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          half_full
);
  logic [AW-1:0] ae_off, af_off;
  logic          flag_rst;

  assign flag_rst = mrst | prst;

  pf_offsets #(.AW(AW), .DW(DW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_ofs (
    .clk(wr_clk), .mrst(mrst), .prst(prst), .def_sel(def_sel),
    .wr_en(wr_en), .ld(ld), .din(din), .ser_en(ser_en), .ser_in(ser_in),
    .ae_off(ae_off), .af_off(af_off)
  );

  // Thresholds are static during traffic, so the read side uses them directly
  pf_rd_flag #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(flag_rst), .rd_count(rd_count), .ae_off(ae_off),
    .almost_empty(almost_empty)
  );

  pf_wr_flags #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(flag_rst), .wr_count(wr_count), .af_off(af_off),
    .almost_full(almost_full), .half_full(half_full)
  );
endmodule

// File: tb/tb_pfifo_status_flags.sv
module tb_pfifo_status_flags;
  localparam int AW    = 11;
  localparam int DW    = 8;
  localparam int OFFW  = AW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, def_sel = 1'b0;
  logic wr_en = 1'b0, ld = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW:0] wr_count = '0, rd_count = '0;
  logic almost_empty, almost_full, half_full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pfifo_status_flags #(.AW(AW), .DW(DW)) dut (
    .wr_clk(clk), .rd_clk(clk), .mrst(mrst), .prst(prst), .def_sel(def_sel),
    .wr_en(wr_en), .ld(ld), .din(din), .ser_en(ser_en), .ser_in(ser_in),
    .wr_count(wr_count), .rd_count(rd_count),
    .almost_empty(almost_empty), .almost_full(almost_full), .half_full(half_full)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic probe_ae(input int off, input string req);
    rd_count = (AW+1)'(off);
    @(negedge clk);
    chk(almost_empty, 1'b1, req, $sformatf("almost_empty at count %0d", off));
    rd_count = (AW+1)'(off + 1);
    @(negedge clk);
    chk(almost_empty, 1'b0, req, $sformatf("almost_empty at count %0d", off + 1));
  endtask

  task automatic probe_af(input int off, input string req);
    wr_count = (AW+1)'(DEPTH - off);
    @(negedge clk);
    chk(almost_full, 1'b1, req, $sformatf("almost_full at free %0d", off));
    wr_count = (AW+1)'(DEPTH - off - 1);
    @(negedge clk);
    chk(almost_full, 1'b0, req, $sformatf("almost_full at free %0d", off + 1));
  endtask

  task automatic do_mrst(input logic sel);
    @(negedge clk);
    mrst = 1'b1; def_sel = sel; rd_count = 500; wr_count = DEPTH;
    @(negedge clk);
    chk(almost_empty, 1'b1, "R1", "almost_empty in master reset");
    chk(almost_full,  1'b0, "R1", "almost_full in master reset");
    chk(half_full,    1'b0, "R1", "half_full in master reset");
    mrst = 1'b0; def_sel = ~sel;
  endtask

  task automatic par_byte(input logic [DW-1:0] b);
    ld = 1'b1; wr_en = 1'b1; din = b;
    @(negedge clk);
    ld = 1'b0; wr_en = 1'b0; din = '0;
  endtask

  task automatic par_load(input int ae, input int af);
    par_byte(DW'(ae)); par_byte(DW'(ae >> DW));
    par_byte(DW'(af)); par_byte(DW'(af >> DW));
  endtask

  task automatic ser_bits(input logic [2*OFFW-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_en = 1'b1; ser_in = v[i];
      @(negedge clk);
    end
    ser_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic t_defaults();
    do_mrst(1'b0);
    probe_ae(7, "R1");
    probe_af(7, "R1");
    do_mrst(1'b1);
    probe_ae(1023, "R1");
    probe_af(1023, "R1");
  endtask

  task automatic t_half();
    wr_count = DEPTH / 2;
    @(negedge clk);
    chk(half_full, 1'b0, "R4", "half_full at exactly half");
    wr_count = DEPTH / 2 + 1;
    @(negedge clk);
    chk(half_full, 1'b1, "R4", "half_full one above half");
    wr_count = 0;
    @(negedge clk);
    chk(half_full, 1'b0, "R4", "half_full when empty");
    chk(almost_full, 1'b0, "R3", "almost_full when empty");
  endtask

  task automatic t_parallel();
    do_mrst(1'b0);
    par_load(300, 517);
    probe_ae(300, "R5");
    probe_af(517, "R5");
    par_load(12, 1500);
    probe_ae(12, "R5");
    probe_af(1500, "R5");
    rd_count = 0;
    @(negedge clk);
    chk(almost_empty, 1'b1, "R2", "almost_empty when empty");
  endtask

  task automatic t_serial();
    do_mrst(1'b1);
    ser_bits({11'd300, 11'd5}, 2*OFFW);
    probe_ae(5, "R6");
    probe_af(300, "R6");
  endtask

  task automatic t_collide();
    do_mrst(1'b0);
    ld = 1'b1; wr_en = 1'b1; din = 8'h20; ser_en = 1'b1; ser_in = 1'b1;
    @(negedge clk);
    ld = 1'b0; wr_en = 1'b0; din = '0; ser_en = 1'b0; ser_in = 1'b0;
    par_byte(8'h00); par_byte(8'h00); par_byte(8'h00);
    probe_ae(32, "R7");
    probe_af(0, "R7");
    ser_bits({11'd17, 11'd9}, 2*OFFW);
    probe_ae(9, "R7");
    probe_af(17, "R7");
  endtask

  task automatic t_stray();
    do_mrst(1'b0);
    par_load(40, 60);
    wr_en = 1'b1; din = 8'hFF;
    repeat (3) @(negedge clk);
    wr_en = 1'b0; ld = 1'b1;
    repeat (3) @(negedge clk);
    ld = 1'b0; din = '0;
    probe_ae(40, "R8");
    probe_af(60, "R8");
    par_load(77, 88);
    probe_ae(77, "R8");
    probe_af(88, "R8");
  endtask

  task automatic t_partial();
    do_mrst(1'b0);
    ser_bits({11'd300, 11'd5}, 2*OFFW);
    par_byte(8'h33);
    ser_bits(22'h3FFFFF, 3);
    // ae now has low byte 0x33 with bits 0..2 set by serial: 0x37 = 55
    prst = 1'b1; rd_count = 500; wr_count = DEPTH;
    ld = 1'b1; wr_en = 1'b1; din = 8'hAA; ser_en = 1'b1; ser_in = 1'b0;
    @(negedge clk);
    chk(almost_empty, 1'b1, "R9", "almost_empty in partial reset");
    chk(almost_full,  1'b0, "R9", "almost_full in partial reset");
    chk(half_full,    1'b0, "R9", "half_full in partial reset");
    prst = 1'b0; ld = 1'b0; wr_en = 1'b0; din = '0; ser_en = 1'b0;
    probe_ae(55, "R9");
    probe_af(300, "R9");
    par_load(200, 1000);
    probe_ae(200, "R9");
    probe_af(1000, "R9");
    par_byte(8'h11);
    ser_bits(22'h3FFFFF, 5);
    @(negedge clk);
    prst = 1'b1;
    @(negedge clk);
    prst = 1'b0;
    ser_bits({11'd600, 11'd3}, 2*OFFW);
    probe_ae(3, "R9");
    probe_af(600, "R9");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_defaults();
    t_half();
    t_parallel();
    t_serial();
    t_collide();
    t_stray();
    t_partial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule